// File: doc/BRIEF.md
# Programmable Period and Width Pulse Generator

This block produces a free-running rectangular pulse train. Both the repeat interval and the high time are counted in cycles of the block clock. A period counter steps once per enabled cycle and returns to zero at the end of each programmed interval. A registered magnitude compare sets the output high for the first W cycles of every interval.

A controller changes the settings through a value bus and two write strobes, one for the period and one for the high time. Writes land in holding registers. They are moved into the working registers only on the cycle where the counter returns to zero. A setting can therefore be changed at any moment without cutting a pulse short or stretching it. An enable input pauses the train in place and forces the output low while it is off.

Top module: `pulse_gen_top`

## Requirements
- R1: With an active period P of 2 or more, the counter runs 0, 1, ..., P-1 and then returns to 0. A period of 0 or 1 gives an interval of one cycle.
- R2: The output is registered. After a clock edge it equals (counter value sampled at that edge < active width). The first enabled edge after reset samples count 0, so the output is high for the first W edges of each interval.
- R3: A write strobe (`ld_period` or `ld_width`) held high across an edge copies `ld_value` into the matching holding register at that edge.
- R4: The working period and width change only on an enabled edge where the counter returns to 0. Writes made in the middle of an interval leave the rest of that interval unchanged.
- R5: An active width of 0 keeps the output low in every cycle.
- R6: An active width that is nonzero and at least the active period keeps the output high in every enabled cycle.
- R7: A synchronous reset sets the counter to 0 and the output low, and loads the parameter defaults into both the holding and the working registers.
- R8: While `en` is low, the counter holds its value and the output is low after the next edge. When `en` returns high, the train resumes from the held count.
- R9: A write made on the same edge where the counter returns to 0 goes only to the holding register. The working register takes the previous holding value, and the new value takes effect at the following return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low pauses the counter and forces the output low |
| ld_period | input | 1 | Write strobe for the period holding register |
| ld_width | input | 1 | Write strobe for the width holding register |
| ld_value | input | CNT_W | Value written by either strobe |
| pulse_out | output | 1 | Registered pulse output |

## Verification
The hardest case to reach is a write that arrives on the exact edge where the counter returns to zero. The new value must skip that boundary and wait a whole extra interval. The bench reaches this case by counting enabled edges from reset with a known default period and raising the strobe just before edge number DP. It then checks that a second interval with the defaults runs before the new period appears. A sweep over every small period and width pair loads the values mid-interval, so each pair also confirms that the first interval keeps the old shape.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

   // upper bound on counter width so that limit arithmetic fits in 64 bits
   localparam int PG_MAX_CNT_W = 30;

   // what the period counter does on a given edge
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_STEP = 2'd1,
      CNT_WRAP = 2'd2
   } cnt_act_e;

endpackage

// File: rtl/pgen_counter.sv
module pgen_counter
   import pgen_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             boundary
);

   localparam int EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] next_ext;
   logic             at_end;
   cnt_act_e         act;

   always_comb begin
      next_ext = {1'b0, cnt} + EXT_W'(1);
      // period 0 and 1 both end the interval every cycle
      at_end   = (next_ext >= {1'b0, period});
      if (!en)         act = CNT_HOLD;
      else if (at_end) act = CNT_WRAP;
      else             act = CNT_STEP;
      boundary = (act == CNT_WRAP);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else begin
         case (act)
            CNT_STEP: cnt <= next_ext[CNT_W-1:0];
            CNT_WRAP: cnt <= '0;
            default:  cnt <= cnt;
         endcase
      end
   end

   // R1: count never reaches the active period (zero is always legal)
   p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
      (cnt < period) || (cnt == '0));

   // R1: a boundary edge leaves the counter at zero
   p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (rst)
      boundary |=> (cnt == '0));

   // R8: disabled cycles freeze the count
   p_hold_when_off_r8: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(cnt));

endmodule

// File: rtl/pgen_shadow.sv
module pgen_shadow #(
   parameter int CNT_W      = 10,
   parameter int DEF_PERIOD = 100,
   parameter int DEF_WIDTH  = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_period,
   input  logic             ld_width,
   input  logic [CNT_W-1:0] ld_value,
   input  logic             commit,
   output logic [CNT_W-1:0] act_period,
   output logic [CNT_W-1:0] act_width
);

   localparam logic [CNT_W-1:0] RST_PERIOD = CNT_W'(DEF_PERIOD);
   localparam logic [CNT_W-1:0] RST_WIDTH  = CNT_W'(DEF_WIDTH);

   logic [CNT_W-1:0] sh_period;
   logic [CNT_W-1:0] sh_width;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_period  <= RST_PERIOD;
         sh_width   <= RST_WIDTH;
         act_period <= RST_PERIOD;
         act_width  <= RST_WIDTH;
      end else begin
         if (ld_period) sh_period <= ld_value;
         if (ld_width)  sh_width  <= ld_value;
         // the working copy takes the holding value present before this edge
         if (commit) begin
            act_period <= sh_period;
            act_width  <= sh_width;
         end
      end
   end

   // R3: a strobe captures the value bus
   p_capture_period_r3: assert property (@(posedge clk) disable iff (rst)
      ld_period |=> (sh_period == $past(ld_value)));

   p_capture_width_r3: assert property (@(posedge clk) disable iff (rst)
      ld_width |=> (sh_width == $past(ld_value)));

   // R4: working settings stay put away from a boundary
   p_stable_mid_interval_r4: assert property (@(posedge clk) disable iff (rst)
      !commit |=> ($stable(act_period) && $stable(act_width)));

   // R9: a boundary takes the older holding value, not the bus
   p_commit_prior_value_r9: assert property (@(posedge clk) disable iff (rst)
      commit |=> (act_period == $past(sh_period)) && (act_width == $past(sh_width)));

endmodule

// File: rtl/pgen_compare.sv
module pgen_compare #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] width,
   output logic             pulse_out
);

   logic below;

   always_comb below = (cnt < width);

   always_ff @(posedge clk) begin
      if (rst) pulse_out <= 1'b0;
      else     pulse_out <= en & below;
   end

   // R5: a zero width never produces a high cycle
   p_zero_width_low_r5: assert property (@(posedge clk) disable iff (rst)
      (width == '0) |=> !pulse_out);

   // R8: output low after any disabled edge
   p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
      !en |=> !pulse_out);

endmodule

// File: rtl/pulse_gen_top.sv
module pulse_gen_top
   import pgen_pkg::*;
#(
   parameter int CNT_W      = 10,
   parameter int DEF_PERIOD = 100,
   parameter int DEF_WIDTH  = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             ld_period,
   input  logic             ld_width,
   input  logic [CNT_W-1:0] ld_value,
   output logic             pulse_out
);

   localparam longint CNT_LIM = 64'd1 << CNT_W;

   // elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > PG_MAX_CNT_W) begin : g_bad_width
      $error("pulse_gen_top: CNT_W out of range");
   end
   if (DEF_PERIOD < 0 || longint'(DEF_PERIOD) >= CNT_LIM) begin : g_bad_def_period
      $error("pulse_gen_top: DEF_PERIOD does not fit CNT_W");
   end
   if (DEF_WIDTH < 0 || longint'(DEF_WIDTH) >= CNT_LIM) begin : g_bad_def_width
      $error("pulse_gen_top: DEF_WIDTH does not fit CNT_W");
   end

   logic [CNT_W-1:0] act_period;
   logic [CNT_W-1:0] act_width;
   logic [CNT_W-1:0] cnt;
   logic             boundary;

   pgen_shadow #(
      .CNT_W      (CNT_W),
      .DEF_PERIOD (DEF_PERIOD),
      .DEF_WIDTH  (DEF_WIDTH)
   ) u_shadow (
      .clk        (clk),
      .rst        (rst),
      .ld_period  (ld_period),
      .ld_width   (ld_width),
      .ld_value   (ld_value),
      .commit     (boundary),
      .act_period (act_period),
      .act_width  (act_width)
   );

   pgen_counter #(
      .CNT_W    (CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .period   (act_period),
      .cnt      (cnt),
      .boundary (boundary)
   );

   pgen_compare #(
      .CNT_W     (CNT_W)
   ) u_compare (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .cnt       (cnt),
      .width     (act_width),
      .pulse_out (pulse_out)
   );

   // R6: a nonzero width covering the whole period keeps the output high
   p_full_width_high_r6: assert property (@(posedge clk) disable iff (rst)
      (en && (act_width >= act_period) && (act_width != '0)) |=> pulse_out);

   // R7: the cycle after reset shows a low output and a zero count
   p_reset_state_r7: assert property (@(posedge clk)
      rst |=> (!pulse_out && (cnt == '0)));

endmodule

// File: tb/pulse_gen_top_tb.sv
module pulse_gen_top_tb;

   localparam int CW = 10;
   localparam int DP = 6;
   localparam int DW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en = 1'b0;
   logic          ld_period = 1'b0;
   logic          ld_width = 1'b0;
   logic [CW-1:0] ld_value = '0;
   logic          pulse_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pulse_gen_top #(
      .CNT_W      (CW),
      .DEF_PERIOD (DP),
      .DEF_WIDTH  (DW)
   ) u_dut (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .ld_period (ld_period),
      .ld_width  (ld_width),
      .ld_value  (ld_value),
      .pulse_out (pulse_out)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input logic exp, input string tag);
      checks++;
      if (pulse_out !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b at %0t", tag, pulse_out, exp, $time);
      end
   endtask

   // expected output for interval index idx under period p and width w
   function automatic logic shape(input int idx, input int p, input int w);
      int pe;
      pe = (p == 0) ? 1 : p;
      return ((idx % pe) < w);
   endfunction

   task automatic do_reset();
      rst = 1'b1; en = 1'b0; ld_period = 1'b0; ld_width = 1'b0;
      step();
      step();
      check(1'b0, "R7 output low in reset");
      rst = 1'b0;
      en  = 1'b1;
   endtask

   initial begin
      string tag;
      logic  e;
      int    kk;

      // sweep: defaults for the first interval, loads issued mid-interval
      for (int p = 0; p <= 9; p++) begin
         for (int w = 0; w <= 10; w++) begin
            int pe;
            pe = (p == 0) ? 1 : p;
            do_reset();
            for (int k = 1; k <= DP + 2 * pe + 2; k++) begin
               ld_period = (k == 3);
               ld_width  = (k == 4);
               ld_value  = CW'((k == 3) ? p : w);
               step();
               ld_period = 1'b0;
               ld_width  = 1'b0;
               if (k <= DP) begin
                  e = shape(k - 1, DP, DW);
                  tag = "R7/R4 defaults hold over mid-interval loads";
               end else begin
                  e = shape(k - 1 - DP, p, w);
                  if (p <= 1)       tag = "R1/R3 one-cycle period";
                  else if (w == 0)  tag = "R5/R3 zero width";
                  else if (w >= p)  tag = "R6/R3 full width";
                  else              tag = "R2/R1/R3 programmed shape";
               end
               check(e, $sformatf("%s p=%0d w=%0d k=%0d", tag, p, w, k));
            end
         end
      end

      // R8: pause and resume
      do_reset();
      kk = 0;
      for (int k = 1; k <= DP + 7; k++) begin
         ld_period = (k == 3);
         ld_width  = (k == 4);
         ld_value  = CW'((k == 3) ? 5 : 2);
         step();
         ld_period = 1'b0;
         ld_width  = 1'b0;
         kk++;
         e = (kk <= DP) ? shape(kk - 1, DP, DW) : shape(kk - 1 - DP, 5, 2);
         check(e, "R8 running before pause");
      end
      en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         check(1'b0, "R8 output low while paused");
      end
      en = 1'b1;
      for (int i = 0; i < 10; i++) begin
         step();
         kk++;
         check(shape(kk - 1 - DP, 5, 2), $sformatf("R8 resumed from held count kk=%0d", kk));
      end

      // R9: write on the boundary edge waits one extra interval
      do_reset();
      for (int k = 1; k <= 3 * DP + 3; k++) begin
         ld_period = (k == DP);
         ld_value  = CW'(3);
         step();
         ld_period = 1'b0;
         if (k <= 2 * DP) e = shape(k - 1, DP, DW);
         else             e = shape(k - 1 - 2 * DP, 3, DW);
         check(e, $sformatf("R9 boundary write deferred k=%0d", k));
      end

      // R7: reset in the middle of a programmed run
      step();
      rst = 1'b1;
      step();
      check(1'b0, "R7 mid-run reset clears output");
      rst = 1'b0;
      for (int k = 1; k <= DP; k++) begin
         step();
         check(shape(k - 1, DP, DW), "R7 defaults restored after reset");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule